// File: doc/BRIEF.md
# Layer-by-Layer Inference Sequencer

This block is the control unit that runs a multi-layer perceptron through a single shared matrix engine, one layer at a time. Each layer passes through a fixed series of steps. The sequencer moves the layer's weights from the weight queue into the array. It streams the layer's input activations in and runs the multiply. It lets the skewed array and the post-processing pipeline empty for a fixed number of cycles. It then copies the quantised results into the activation buffer that the next layer will read. The two activation buffers swap roles after every layer, so one layer's results are the next layer's inputs without any host traffic.

The host programs a layer count and pulses start. Before every later layer, the sequencer waits until the host reports that the next layer's weights are in the weight queue. That report may arrive while the current layer is still draining. In that case it is remembered and the wait step lasts a single cycle. The arithmetic datapath is outside this block. The sequencer only drives a level "go" strobe to each unit and waits for that unit's completion input.

Top module: `layer_sequencer`

## Requirements
- R1: `state_o` carries the phase as a 4-bit code: 0 idle, 1 weight load, 2 activation load, 3 compute, 4 drain, 5 transfer, 6 next-layer, 7 weight wait. After reset the block is idle, with `busy_o`, `done_o` and `buf_sel_o` all 0.
- R2: A `start_i` pulse in the idle phase with a nonzero `layers_i` moves the block to weight load on the next cycle and latches the layer count. A start with `layers_i` = 0, or a start outside the idle phase, has no effect.
- R3: In weight load, activation load, compute and transfer, the matching go output (`wload_go_o`, `aload_go_o`, `comp_go_o`, `xfer_go_o`) is high, and no other go output is high. The block leaves that phase on the edge where the matching done input is high. The phase order is 1, 2, 3, 4, 5, 6.
- R4: The drain phase lasts exactly ARRAY_SKEW + POST_LAT cycles, then gives way to transfer.
- R5: `buf_sel_o` is cleared to 0 when a run starts. It inverts exactly once per layer, on the edge that leaves transfer, and at no other time.
- R6: From next-layer the block goes to weight wait when more layers remain, and to idle after the final layer. `done_o` is high only during the next-layer cycle of the final layer.
- R7: Weight wait holds until the weights-ready flag has been seen. A `wt_ready_i` pulse seen during drain, transfer, next-layer or weight wait is remembered. A pulse remembered from an earlier phase makes weight wait last one cycle before weight load.
- R8: A `wt_ready_i` pulse during weight load, activation load or compute is ignored. The block then stays in weight wait until a new pulse arrives.
- R9: `busy_o` is high in every phase except idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a run |
| layers_i | input | LAYER_W | Number of layers in the run |
| wt_ready_i | input | 1 | Host flag: next layer's weights are queued |
| wload_go_o | output | 1 | Weight queue: move weights into array |
| wload_done_i | input | 1 | Weight move finished |
| aload_go_o | output | 1 | Activation buffer: stream inputs |
| aload_done_i | input | 1 | Activation stream finished |
| comp_go_o | output | 1 | Array: run the multiply |
| comp_done_i | input | 1 | Multiply finished |
| xfer_go_o | output | 1 | Output buffer: copy results to the other activation buffer |
| xfer_done_i | input | 1 | Copy finished |
| buf_sel_o | output | 1 | Activation buffer the current layer reads; results go to the other |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of the final layer |
| state_o | output | 4 | Current phase code |

## Verification
The bench builds the block with LAYER_W = 3, ARRAY_SKEW = 1 and POST_LAT = 3. The drain window is therefore four cycles long, and counting it is visible without long waits. Runs of the maximum seven layers stay short enough to repeat many times inside a random sequence. Directed runs cover three aspects: the exact phase trace and buffer toggles of a three-layer run, a ready flag given too early, and a ready flag given late. A random stream follows that mixes starts issued while busy, zero layer counts and arbitrary done latencies.

// File: rtl/mlseq_pkg.sv
package mlseq_pkg;
   // phase codes; the numeric order is the order a layer walks through
   typedef enum logic [3:0] {
      SQ_IDLE  = 4'd0,
      SQ_LDW   = 4'd1,
      SQ_LDA   = 4'd2,
      SQ_CALC  = 4'd3,
      SQ_DRAIN = 4'd4,
      SQ_XFER  = 4'd5,
      SQ_NEXT  = 4'd6,
      SQ_WAITW = 4'd7
   } seq_state_e;
endpackage

// File: rtl/mlseq_drain_timer.sv
module mlseq_drain_timer #(
   parameter int ARRAY_SKEW = 1,
   parameter int POST_LAT   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic last_o
);
   localparam int DRAIN_CYC = ARRAY_SKEW + POST_LAT;

   if (DRAIN_CYC < 1 || DRAIN_CYC > 16) begin : g_bad_len
      $error("drain length must fit a 4-bit counter");
   end

   if (DRAIN_CYC == 1) begin : g_single
      assign last_o = run_i;
   end else begin : g_count
      localparam logic [3:0] LAST_CNT = 4'(DRAIN_CYC - 1);
      logic [3:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               cnt_q <= '0;
         else if (!run_i || cnt_q == LAST_CNT)     cnt_q <= '0;
         else                                      cnt_q <= cnt_q + 4'd1;
      end
      assign last_o = run_i && (cnt_q == LAST_CNT);

      // R4: the count never runs past the drain window
      assert_drain_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
         run_i |-> (cnt_q <= LAST_CNT));
      // R4: a fresh drain window always begins at zero
      assert_drain_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (run_i && !$past(run_i)) |-> (cnt_q == 4'd0));
   end
endmodule

// File: rtl/mlseq_layer_ctr.sv
module mlseq_layer_ctr #(
   parameter int LAYER_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [LAYER_W-1:0] count_i,
   input  logic               step_i,
   output logic               last_o
);
   if (LAYER_W < 1 || LAYER_W > 16) begin : g_bad_w
      $error("LAYER_W out of range");
   end

   logic [LAYER_W-1:0] total_q, idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         total_q <= '0;
         idx_q   <= '0;
      end else if (load_i) begin
         total_q <= count_i;
         idx_q   <= '0;
      end else if (step_i) begin
         idx_q   <= idx_q + 1'b1;
      end
   end

   assign last_o = (idx_q == total_q - 1'b1);

   // R6: the layer index stays below the programmed count
   assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (total_q != '0) |-> (idx_q < total_q));
endmodule

// File: rtl/mlseq_pingpong.sv
module mlseq_pingpong (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic flip_i,
   output logic sel_o
);
   logic sel_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sel_q <= 1'b0;
      else if (clear_i) sel_q <= 1'b0;
      else if (flip_i)  sel_q <= ~sel_q;
   end
   assign sel_o = sel_q;
endmodule

// File: rtl/mlseq_wt_latch.sv
module mlseq_wt_latch
   import mlseq_pkg::*;
#(
   parameter bit OVERLAP = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  seq_state_e state_i,
   input  logic       ready_i,
   input  logic       consume_i,
   output logic       avail_o
);
   logic window;
   logic pend_q;

   if (OVERLAP) begin : g_overlap
      assign window = (state_i == SQ_DRAIN) || (state_i == SQ_XFER) ||
                      (state_i == SQ_NEXT)  || (state_i == SQ_WAITW);
   end else begin : g_strict
      assign window = (state_i == SQ_WAITW);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pend_q <= 1'b0;
      else if (consume_i)          pend_q <= 1'b0;
      else if (window && ready_i)  pend_q <= 1'b1;
   end

   assign avail_o = pend_q || (ready_i && state_i == SQ_WAITW);

   // R8: no pending flag appears while the current layer still uses the queue
   assert_early_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == SQ_LDW || state_i == SQ_LDA || state_i == SQ_CALC) && !$past(pend_q)
      |-> !pend_q);
endmodule

// File: rtl/layer_sequencer.sv
module layer_sequencer
   import mlseq_pkg::*;
#(
   parameter int LAYER_W    = 3,
   parameter int ARRAY_SKEW = 1,
   parameter int POST_LAT   = 3,
   parameter bit WT_OVERLAP = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [LAYER_W-1:0] layers_i,
   input  logic               wt_ready_i,
   output logic               wload_go_o,
   input  logic               wload_done_i,
   output logic               aload_go_o,
   input  logic               aload_done_i,
   output logic               comp_go_o,
   input  logic               comp_done_i,
   output logic               xfer_go_o,
   input  logic               xfer_done_i,
   output logic               buf_sel_o,
   output logic               busy_o,
   output logic               done_o,
   output logic [3:0]         state_o
);
   seq_state_e st_q, st_nxt;
   logic launch, drain_last, layer_last, wt_avail, wt_take, flip;

   assign launch  = (st_q == SQ_IDLE) && start_i && (layers_i != '0);
   assign wt_take = ((st_q == SQ_WAITW) && wt_avail) || launch;
   assign flip    = (st_q == SQ_XFER) && xfer_done_i;

   mlseq_drain_timer #(.ARRAY_SKEW(ARRAY_SKEW), .POST_LAT(POST_LAT)) u_drain (
      .clk(clk), .rst_n(rst_n), .run_i(st_q == SQ_DRAIN), .last_o(drain_last));

   mlseq_layer_ctr #(.LAYER_W(LAYER_W)) u_layers (
      .clk(clk), .rst_n(rst_n), .load_i(launch), .count_i(layers_i),
      .step_i((st_q == SQ_NEXT) && !layer_last), .last_o(layer_last));

   mlseq_pingpong u_pp (
      .clk(clk), .rst_n(rst_n), .clear_i(launch), .flip_i(flip), .sel_o(buf_sel_o));

   mlseq_wt_latch #(.OVERLAP(WT_OVERLAP)) u_wt (
      .clk(clk), .rst_n(rst_n), .state_i(st_q), .ready_i(wt_ready_i),
      .consume_i(wt_take), .avail_o(wt_avail));

   always_comb begin
      st_nxt = st_q;
      unique case (st_q)
         SQ_IDLE:  if (launch)       st_nxt = SQ_LDW;
         SQ_LDW:   if (wload_done_i) st_nxt = SQ_LDA;
         SQ_LDA:   if (aload_done_i) st_nxt = SQ_CALC;
         SQ_CALC:  if (comp_done_i)  st_nxt = SQ_DRAIN;
         SQ_DRAIN: if (drain_last)   st_nxt = SQ_XFER;
         SQ_XFER:  if (xfer_done_i)  st_nxt = SQ_NEXT;
         SQ_NEXT:  st_nxt = layer_last ? SQ_IDLE : SQ_WAITW;
         SQ_WAITW: if (wt_avail)     st_nxt = SQ_LDW;
         default:  st_nxt = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SQ_IDLE;
      else        st_q <= st_nxt;
   end

   assign wload_go_o = (st_q == SQ_LDW);
   assign aload_go_o = (st_q == SQ_LDA);
   assign comp_go_o  = (st_q == SQ_CALC);
   assign xfer_go_o  = (st_q == SQ_XFER);
   assign busy_o     = (st_q != SQ_IDLE);
   assign done_o     = (st_q == SQ_NEXT) && layer_last;
   assign state_o    = st_q;

   // R1: only the eight defined phase codes ever appear
   assert_state_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      state_o <= 4'd7);
   // R5: the buffer select moves only after transfer or at a launch from idle
   assert_sel_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_sel_o != $past(buf_sel_o)) |-> ($past(st_q) == SQ_XFER || $past(st_q) == SQ_IDLE));
   // R6: completion is followed by idle
   assert_done_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (st_q == SQ_IDLE));
   // R7: weight load is only entered from idle or weight wait
   assert_ldw_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_LDW && $past(st_q) != SQ_LDW) |-> ($past(st_q) == SQ_IDLE || $past(st_q) == SQ_WAITW));
   // R7: weight wait holds while no ready flag is available
   assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_WAITW && !wt_avail) |=> (st_q == SQ_WAITW));
   // R3: at most one unit is strobed at a time
   assert_go_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wload_go_o, aload_go_o, comp_go_o, xfer_go_o}));
endmodule

// File: tb/test_layer_sequencer.sv
module test_layer_sequencer;
   localparam int LW = 3;
   localparam int SK = 1;
   localparam int PL = 3;
   localparam int DR = SK + PL;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [LW-1:0] layers_i = '0;
   logic wt_ready_i = 1'b0;
   logic wload_done_i = 1'b0, aload_done_i = 1'b0, comp_done_i = 1'b0, xfer_done_i = 1'b0;
   logic wload_go_o, aload_go_o, comp_go_o, xfer_go_o;
   logic buf_sel_o, busy_o, done_o;
   logic [3:0] state_o;

   always #2 clk = ~clk;

   layer_sequencer #(.LAYER_W(LW), .ARRAY_SKEW(SK), .POST_LAT(PL), .WT_OVERLAP(1'b1)) i_layer_sequencer (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .layers_i(layers_i), .wt_ready_i(wt_ready_i),
      .wload_go_o(wload_go_o), .wload_done_i(wload_done_i),
      .aload_go_o(aload_go_o), .aload_done_i(aload_done_i),
      .comp_go_o(comp_go_o), .comp_done_i(comp_done_i),
      .xfer_go_o(xfer_go_o), .xfer_done_i(xfer_done_i),
      .buf_sel_o(buf_sel_o), .busy_o(busy_o), .done_o(done_o), .state_o(state_o));

   int total = 0;
   int bad = 0;

   // bench reference model, written from the requirements
   int m_st = 0, m_sel = 0, m_idx = 0, m_cnt = 0, m_dr = 0;
   bit m_pend = 0;

   task automatic chk(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string tag_of(int s);
      case (s)
         0: return "R2 idle";
         4: return "R4 drain";
         6: return "R6 next";
         7: return "R7 wait";
         default: return "R3 phase";
      endcase
   endfunction

   function automatic int exp_go(int s);
      return {28'd0, s == 1, s == 2, s == 3, s == 5};
   endfunction

   task automatic compare();
      int done_e;
      done_e = (m_st == 6 && m_idx == m_cnt - 1) ? 1 : 0;
      chk(state_o == m_st, tag_of(m_st), state_o, m_st);
      chk(buf_sel_o == m_sel, "R5 buf_sel", buf_sel_o, m_sel);
      chk(busy_o == (m_st != 0), "R9 busy", busy_o, m_st != 0);
      chk(done_o == done_e, "R6 done", done_o, done_e);
      chk({wload_go_o, aload_go_o, comp_go_o, xfer_go_o} == exp_go(m_st), "R3 go strobes",
          {wload_go_o, aload_go_o, comp_go_o, xfer_go_o}, exp_go(m_st));
   endtask

   task automatic advance();
      bit last, win, avail, launch;
      int nst;
      last   = (m_idx == m_cnt - 1);
      win    = (m_st >= 4);
      avail  = m_pend || (wt_ready_i && m_st == 7);
      launch = (m_st == 0) && start_i && (layers_i != 0);
      nst    = m_st;
      case (m_st)
         0: if (launch) begin m_cnt = layers_i; m_idx = 0; m_sel = 0; nst = 1; end
         1: if (wload_done_i) nst = 2;
         2: if (aload_done_i) nst = 3;
         3: if (comp_done_i) begin nst = 4; m_dr = 0; end
         4: if (m_dr == DR - 1) nst = 5; else m_dr++;
         5: if (xfer_done_i) begin nst = 6; m_sel ^= 1; end
         6: if (last) nst = 0; else begin m_idx++; nst = 7; end
         7: if (avail) nst = 1;
         default: nst = 0;
      endcase
      if ((m_st == 7 && avail) || launch) m_pend = 0;
      else if (win && wt_ready_i) m_pend = 1;
      m_st = nst;
   endtask

   task automatic cyc();
      advance();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic all_done(bit v);
      wload_done_i = v; aload_done_i = v; comp_done_i = v; xfer_done_i = v;
   endtask

   initial begin
      #800000;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int toggles, dones, waits, prev_sel;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(state_o == 4'd0, "R1 reset state", state_o, 0);
      chk(busy_o == 1'b0 && done_o == 1'b0, "R1 reset flags", {busy_o, done_o}, 0);
      chk(buf_sel_o == 1'b0, "R1 reset buf_sel", buf_sel_o, 0);
      rst_n = 1'b1;

      // R2: zero layer count does not launch
      start_i = 1; layers_i = 0; cyc();
      start_i = 0; cyc();
      chk(state_o == 4'd0, "R2 zero count ignored", state_o, 0);

      // directed three-layer run with weights ready during each drain
      all_done(1);
      start_i = 1; layers_i = 3;
      toggles = 0; dones = 0; waits = 0; prev_sel = 0;
      for (int i = 0; i < 60; i++) begin
         wt_ready_i = (m_st == 4);
         cyc();
         start_i = 0;
         if (buf_sel_o != prev_sel) toggles++;
         prev_sel = buf_sel_o;
         if (done_o) dones++;
         if (state_o == 4'd7) waits++;
      end
      wt_ready_i = 0;
      chk(toggles == 3, "R5 three toggles in three layers", toggles, 3);
      chk(dones == 1, "R6 single done pulse", dones, 1);
      chk(waits == 2, "R7 overlapped weights give one-cycle waits", waits, 2);

      // R8: ready only during compute is ignored
      start_i = 1; layers_i = 2;
      for (int i = 0; i < 40 && m_st != 7; i++) begin
         wt_ready_i = (m_st == 3);
         cyc();
         start_i = 0;
      end
      wt_ready_i = 0;
      repeat (10) cyc();
      chk(state_o == 4'd7, "R8 early ready ignored", state_o, 7);
      // R7: late ready inside the wait phase releases it
      wt_ready_i = 1; cyc();
      wt_ready_i = 0;
      chk(state_o == 4'd1, "R7 late ready leaves wait", state_o, 1);
      for (int i = 0; i < 40 && m_st != 0; i++) cyc();

      // random mix: slow responders, starts while busy, sparse ready
      for (int i = 0; i < 4000; i++) begin
         start_i      = ($urandom % 100) < 8;
         layers_i     = LW'($urandom % 8);
         wload_done_i = ($urandom % 3) == 0;
         aload_done_i = ($urandom % 3) == 0;
         comp_done_i  = ($urandom % 4) == 0;
         xfer_done_i  = ($urandom % 3) == 0;
         wt_ready_i   = ($urandom % 100) < 12;
         cyc();
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule